// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This peripheral counts down a 10-bit tick counter on a small halfword register bus with byte lanes. A built-in prescaler turns the system clock into one decrement tick every `TICK_CLKS` clocks. At 250 MHz, the default prescaler value gives a 0.6 s tick. Software sets the initial tick count, forces the counter back to that count by writing the reload register, and starts or stops counting with a halt bit. The reload register also returns the live count when read.

Expiry is handled in two stages. The first expiry sets a timeout status flag. It also pulses an interrupt request if the external enable input is high, and the counter reloads. If the counter expires again before software clears the timeout flag, the block sets a second-timeout flag and pulses a reset request, unless the no-reboot input is high. A further expiry while the second-timeout flag is still set marks a boot-failure flag and requests reset again. Every status flag is cleared by writing one to it.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the halt bit (control 0x08, bit 11) is 1, the initial value and the counter are both 4, all status flags read 0, and `irq_o` and `reset_req_o` are low.
- R2: The initial-value register at 0x12 stores a 10-bit count in bits [9:0]. It reads back the stored value, with bits [15:10] reading 0.
- R3: A write to 0x12 whose resulting 10-bit value is 0, 1, 2 or 3 leaves the stored initial value unchanged.
- R4: Any write to 0x00 loads the counter with the initial value, and a read of 0x00 returns the current counter value.
- R5: While the halt bit is 1 the counter holds its value. While it is 0 the counter decrements once every `TICK_CLKS` clocks, with the prescaler restarting on a reload write.
- R6: When a tick arrives with the counter at 0 and the timeout flag (0x04 bit 3) clear, the block sets that flag, reloads the counter, and pulses `irq_o` high for one clock when `irq_en_i` is high. With the initial value N, this expiry falls (N+1)·`TICK_CLKS` clocks after the reload write.
- R7: With `irq_en_i` low, a first expiry raises no `irq_o` but still sets the timeout flag.
- R8: An expiry while the timeout flag is set and the second-timeout flag (0x06 bit 1) is clear sets the second-timeout flag and pulses `reset_req_o` for one clock. It raises no `irq_o`.
- R9: While `no_reboot_i` is high, `reset_req_o` stays low, but the status flags are still set.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an expiry sets a bit in the same cycle that a write clears it, the set takes priority.
- R11: An expiry while both the timeout and second-timeout flags are set sets the boot-failure flag (0x06 bit 2) and pulses `reset_req_o` again, subject to R9.
- R12: Byte enables select the lanes a write updates: `bus_be_i[0]` covers bits [7:0] and `bus_be_i[1]` covers bits [15:8]. A lane that is not enabled leaves its bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte address inside the 32-byte window |
| bus_be_i | input | 2 | Byte-lane enables |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from the address |
| irq_en_i | input | 1 | Allows the first-stage interrupt |
| no_reboot_i | input | 1 | Blocks the reset request when high |
| irq_o | output | 1 | One-clock interrupt request pulse |
| reset_req_o | output | 1 | One-clock reset request pulse |

## Verification
The hardest state to reach is the boot-failure flag. It needs three expiries in a row with no status cleared in between, each separated by the full (N+1)-tick period. The bench shortens the tick to four clocks and sets the initial value to the minimum of 4. It then lets the counter run through three consecutive 20-clock windows and checks the exact cycle of each pulse. Status is read between the windows without touching it. The no-reboot and interrupt-disable cases repeat the same run with a single input changed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BUS_DW = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] A_STS1   = 5'h04;
  localparam logic [ADDR_W-1:0] A_STS2   = 5'h06;
  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] A_INIT   = 5'h12;

  localparam int HALT_BIT = 11;
  localparam int TO_BIT   = 3;
  localparam int TO2_BIT  = 1;
  localparam int BOOT_BIT = 2;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int TICK_CLKS = 150_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;

  generate
    if (TICK_CLKS == 1) begin : g_direct
      assign tick_o = run_i && !clr_i;
    end else begin : g_div
      logic [PW-1:0] div_q;
      logic          wrap;
      assign wrap   = (div_q == PW'(TICK_CLKS - 1));
      assign tick_o = run_i && !clr_i && wrap;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                div_q <= '0;
        else if (clr_i || !run_i)   div_q <= '0;
        else if (wrap)              div_q <= '0;
        else                        div_q <= div_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CNT_W   = 10,
  parameter int RST_CNT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] init_i,
  input  logic             load_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o    = cnt_q;
  assign expire_o = tick_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= CNT_W'(RST_CNT);
    else if (load_i)   cnt_q <= init_i;
    else if (tick_i)   cnt_q <= (cnt_q == '0) ? init_i : cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic irq_en_i,
  input  logic no_reboot_i,
  input  logic clr_to_i,
  input  logic clr_to2_i,
  input  logic clr_boot_i,
  output logic to_o,
  output logic to2_o,
  output logic boot_o,
  output logic irq_o,
  output logic reset_req_o
);
  logic to_q, to2_q, boot_q, irq_q, rreq_q;
  logic stage1, stage2, stage3;

  assign stage1 = expire_i && !to_q;
  assign stage2 = expire_i && to_q && !to2_q;
  assign stage3 = expire_i && to_q && to2_q;

  // set has priority over a same-cycle write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_q   <= 1'b0;
      to2_q  <= 1'b0;
      boot_q <= 1'b0;
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      to_q   <= (to_q   && !clr_to_i)   || expire_i;
      to2_q  <= (to2_q  && !clr_to2_i)  || stage2;
      boot_q <= (boot_q && !clr_boot_i) || stage3;
      irq_q  <= stage1 && irq_en_i;
      rreq_q <= (stage2 || stage3) && !no_reboot_i;
    end
  end

  assign to_o        = to_q;
  assign to2_o       = to2_q;
  assign boot_o      = boot_q;
  assign irq_o       = irq_q;
  assign reset_req_o = rreq_q;
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int TICK_CLKS = 150_000_000,
  parameter int INIT_RST  = 4,
  parameter int INIT_MIN  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [1:0]        bus_be_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic [BUS_DW-1:0] bus_rdata_o,
  input  logic              irq_en_i,
  input  logic              no_reboot_i,
  output logic              irq_o,
  output logic              reset_req_o
);
  localparam int PAD_W = BUS_DW - CNT_W;

  logic              wr, rd;
  logic [BUS_DW-1:0] wmask;
  logic              hit_reload, hit_sts1, hit_sts2, hit_ctrl, hit_init;
  logic [CNT_W-1:0]  init_q, init_cand, cnt_w;
  logic              init_ok, halt_q, tick_w, expire_w;
  logic              to_w, to2_w, boot_w;
  logic              clr_to, clr_to2, clr_boot;
  logic              unused_wdata;

  assign wr    = bus_req_i && bus_we_i;
  assign rd    = bus_req_i && !bus_we_i;
  assign wmask = {{8{bus_be_i[1]}}, {8{bus_be_i[0]}}};

  assign hit_reload = wr && (bus_addr_i == A_RELOAD);
  assign hit_sts1   = wr && (bus_addr_i == A_STS1);
  assign hit_sts2   = wr && (bus_addr_i == A_STS2);
  assign hit_ctrl   = wr && (bus_addr_i == A_CTRL);
  assign hit_init   = wr && (bus_addr_i == A_INIT);

  assign init_cand = (init_q & ~wmask[CNT_W-1:0]) | (bus_wdata_i[CNT_W-1:0] & wmask[CNT_W-1:0]);
  assign init_ok   = init_cand >= CNT_W'(INIT_MIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= CNT_W'(INIT_RST);
      halt_q <= 1'b1;
    end else begin
      if (hit_init && init_ok)             init_q <= init_cand;
      if (hit_ctrl && wmask[HALT_BIT])     halt_q <= bus_wdata_i[HALT_BIT];
    end
  end

  assign clr_to   = hit_sts1 && wmask[TO_BIT]   && bus_wdata_i[TO_BIT];
  assign clr_to2  = hit_sts2 && wmask[TO2_BIT]  && bus_wdata_i[TO2_BIT];
  assign clr_boot = hit_sts2 && wmask[BOOT_BIT] && bus_wdata_i[BOOT_BIT];
  assign unused_wdata = ^bus_wdata_i;

  wdog_prescaler #(.TICK_CLKS(TICK_CLKS)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (!halt_q),
    .clr_i (hit_reload),
    .tick_o(tick_w)
  );

  wdog_countdown #(.CNT_W(CNT_W), .RST_CNT(INIT_RST)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (init_q),
    .load_i  (hit_reload),
    .tick_i  (tick_w),
    .cnt_o   (cnt_w),
    .expire_o(expire_w)
  );

  wdog_status u_sts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .expire_i   (expire_w),
    .irq_en_i   (irq_en_i),
    .no_reboot_i(no_reboot_i),
    .clr_to_i   (clr_to),
    .clr_to2_i  (clr_to2),
    .clr_boot_i (clr_boot),
    .to_o       (to_w),
    .to2_o      (to2_w),
    .boot_o     (boot_w),
    .irq_o      (irq_o),
    .reset_req_o(reset_req_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      unique case (bus_addr_i)
        A_RELOAD: bus_rdata_o = {{PAD_W{1'b0}}, cnt_w};
        A_INIT:   bus_rdata_o = {{PAD_W{1'b0}}, init_q};
        A_CTRL:   bus_rdata_o[HALT_BIT] = halt_q;
        A_STS1:   bus_rdata_o[TO_BIT]   = to_w;
        A_STS2: begin
          bus_rdata_o[TO2_BIT]  = to2_w;
          bus_rdata_o[BOOT_BIT] = boot_w;
        end
        default:  bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
  parameter int CNT_W    = 10,
  parameter int INIT_MIN = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             halt_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] init_i,
  input logic             to_i,
  input logic             irq_en_i,
  input logic             no_reboot_i,
  input logic             irq_i,
  input logic             rreq_i
);
  AST_RELOAD_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_i == $past(init_i)); // R4
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !load_i) |=> cnt_i == $past(cnt_i)); // R5
  AST_INIT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i >= CNT_W'(INIT_MIN)); // R3
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(irq_en_i)); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i); // R6
  AST_RST_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rreq_i |-> !$past(no_reboot_i)); // R9
  AST_RST_AFTER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rreq_i |-> $past(to_i)); // R8
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CNT_W(CNT_W), .INIT_MIN(INIT_MIN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (hit_reload),
  .halt_i     (halt_q),
  .cnt_i      (cnt_w),
  .init_i     (init_q),
  .to_i       (to_w),
  .irq_en_i   (irq_en_i),
  .no_reboot_i(no_reboot_i),
  .irq_i      (irq_o),
  .rreq_i     (reset_req_o)
);

// File: tb/wdog_two_stage_tb.sv
`timescale 1ns/1ps
module wdog_two_stage_tb;
  localparam int TICKS = 4;
  localparam int NVEC  = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_en = 1'b1, no_reboot = 1'b0;
  logic        irq, rreq;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  wdog_two_stage #(.TICK_CLKS(TICKS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_en_i(irq_en), .no_reboot_i(no_reboot), .irq_o(irq), .reset_req_o(rreq)
  );

  // {write, addr, byte enables, data or expected}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 5'h12, 2'd3, 16'h0123}, {1'b0, 5'h12, 2'd0, 16'h0123},
    {1'b1, 5'h12, 2'd3, 16'hFC02}, {1'b0, 5'h12, 2'd0, 16'h0123},
    {1'b1, 5'h12, 2'd3, 16'h0003}, {1'b0, 5'h12, 2'd0, 16'h0123},
    {1'b1, 5'h12, 2'd1, 16'h0055}, {1'b0, 5'h12, 2'd0, 16'h0155},
    {1'b1, 5'h12, 2'd2, 16'h0200}, {1'b0, 5'h12, 2'd0, 16'h0255},
    {1'b1, 5'h12, 2'd3, 16'hFFFF}, {1'b0, 5'h12, 2'd0, 16'h03FF},
    {1'b1, 5'h08, 2'd1, 16'h00FF}, {1'b0, 5'h08, 2'd0, 16'h0800},
    {1'b0, 5'h00, 2'd0, 16'h0004}
  };
  string vec_req [NVEC] = '{"R2", "R2", "R3", "R3", "R3", "R3", "R12", "R12",
                            "R12", "R12", "R2", "R2", "R12", "R12", "R4"};

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #0.5;
    d = rdata;
    req = 1'b0;
    #0.5;
  endtask

  task automatic watch(input int n, output int f_irq, output int f_rst,
                       output int n_irq, output int n_rst);
    f_irq = 0; f_rst = 0; n_irq = 0; n_rst = 0;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #1;
      if (irq)  begin n_irq++; if (f_irq == 0) f_irq = k; end
      if (rreq) begin n_rst++; if (f_rst == 0) f_rst = k; end
    end
  endtask

  initial begin
    #800_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int fi, fr, ni, nr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", irq, 0); chk("R1", rreq, 0);
    rd(5'h08, v); chk("R1", v, 16'h0800);
    rd(5'h12, v); chk("R1", v, 16'h0004);
    rd(5'h00, v); chk("R1", v, 16'h0004);
    rd(5'h04, v); chk("R1", v, 16'h0000);
    rd(5'h06, v); chk("R1", v, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][23]) wr(VEC[i][22:18], VEC[i][17:16], VEC[i][15:0]);
      else begin
        @(negedge clk);
        rd(VEC[i][22:18], v);
        chk(vec_req[i], v, VEC[i][15:0]);
      end
    end

    // R5 halted counter holds
    wr(5'h12, 2'd3, 16'h0004);
    wr(5'h00, 2'd3, 16'h0000);
    repeat (30) @(negedge clk);
    rd(5'h00, v); chk("R5", v, 4);

    // R6 first expiry, R8 second, R11 boot
    wr(5'h08, 2'd2, 16'h0000);
    wr(5'h00, 2'd3, 16'h0000);
    watch(20, fi, fr, ni, nr);
    chk("R6", fi, 20); chk("R6", ni, 1); chk("R6", nr, 0);
    rd(5'h04, v); chk("R6", v, 16'h0008);
    rd(5'h00, v); chk("R6", v, 4);
    watch(20, fi, fr, ni, nr);
    chk("R8", fr, 20); chk("R8", nr, 1); chk("R8", ni, 0);
    rd(5'h06, v); chk("R8", v, 16'h0002);
    watch(20, fi, fr, ni, nr);
    chk("R11", fr, 20);
    rd(5'h06, v); chk("R11", v, 16'h0006);

    // R10 write-one-to-clear
    wr(5'h08, 2'd2, 16'h0800);
    wr(5'h06, 2'd3, 16'h0000); rd(5'h06, v); chk("R10", v, 16'h0006);
    wr(5'h06, 2'd3, 16'h0004); rd(5'h06, v); chk("R10", v, 16'h0002);
    wr(5'h06, 2'd3, 16'hFFFF); rd(5'h06, v); chk("R10", v, 16'h0000);
    wr(5'h04, 2'd3, 16'h0000); rd(5'h04, v); chk("R10", v, 16'h0008);
    wr(5'h04, 2'd1, 16'h0008); rd(5'h04, v); chk("R10", v, 16'h0000);

    // R7 interrupt disabled
    irq_en = 1'b0;
    wr(5'h08, 2'd2, 16'h0000);
    wr(5'h00, 2'd3, 16'h0000);
    watch(22, fi, fr, ni, nr);
    chk("R7", ni, 0);
    rd(5'h04, v); chk("R7", v, 16'h0008);
    wr(5'h08, 2'd2, 16'h0800);
    wr(5'h04, 2'd3, 16'h0008);

    // R9 no-reboot gate, R5 decrement
    irq_en = 1'b1; no_reboot = 1'b1;
    wr(5'h08, 2'd2, 16'h0000);
    wr(5'h00, 2'd3, 16'h0000);
    watch(4, fi, fr, ni, nr);
    rd(5'h00, v); chk("R5", v, 3);
    watch(40, fi, fr, ni, nr);
    chk("R9", nr, 0);
    rd(5'h06, v); chk("R9", v, 16'h0002);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule